// File: doc/BRIEF.md
# Pseudo-Sync Pulse Copy-Protection Detector

This block watches a digitised composite sync stream, one sample per pixel clock, for the narrow extra sync pulses that copy-protected analog video carries in its vertical blanking interval. It numbers the lines of each frame from the frame and line strobes. It measures the low time of every sync pulse and keeps only those pulses whose width lies inside a width band. Such a pulse counts only when it starts inside a band of lines.

At the end of the line band the block compares the count with a threshold chosen by a two-bit code. It then sets or clears a single detect flag, which holds until the next frame's evaluation. The line band and the width band come either from built-in presets, selected by a PAL/NTSC bit and a standard/progressive bit, or from programmed values. A correction bit halves the measured widths when the stream is sampled at twice the nominal rate.

Top module: `cpd_detector`

## Requirements
- R1: After reset `detected` is 0 and stays 0 until the first evaluation.
- R2: A pulse is a run of cycles with `sync_n` low. Its width is the number of such cycles. It qualifies only if wmin <= width <= wmax, with both limits inclusive.
- R3: When `cfg_oversample` is 1, the measured width is halved (rounded down) before the limit comparison.
- R4: `frame_start` makes the current line 1. Each later `line_start` adds one. A pulse belongs to the line in which `sync_n` fell, and it counts only if that line lies in [first, last].
- R5: In standard mode (`cfg_progressive` = 0) only qualified pulses in the final three window lines count (last-2 through last, clipped to first). The required number comes from `cfg_count_sel`: 00 needs 6, 01 needs 4, 10 needs 5, 11 needs 7.
- R6: In progressive mode (`cfg_progressive` = 1) every qualified pulse in the whole window counts against the same required number.
- R7: With `cfg_use_prog` = 1 the window and width limits come from `cfg_first`, `cfg_last`, `cfg_wmin` and `cfg_wmax`. With 0 these inputs are ignored and presets are used: standard NTSC lines 13..21 width 6..9; standard PAL lines 7..15 width 5..8; progressive NTSC lines 26..34 width 3..5; progressive PAL lines 20..28 width 3..5.
- R8: `cfg_pal` = 1 selects the PAL preset and 0 selects the NTSC preset.
- R9: Evaluation happens on the `line_start` that ends line `last`. There `detected` becomes (count >= required). It holds its value at every other time. `frame_start` clears the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_n | input | 1 | Sliced composite sync, low during a pulse |
| line_start | input | 1 | One-cycle strobe at each new line |
| frame_start | input | 1 | One-cycle strobe at frame start (line 1) |
| cfg_wmin | input | 4 | Programmed minimum pulse width |
| cfg_wmax | input | 4 | Programmed maximum pulse width |
| cfg_first | input | 6 | Programmed first window line |
| cfg_last | input | 6 | Programmed last window line |
| cfg_count_sel | input | 2 | Required-count code |
| cfg_use_prog | input | 1 | 1: programmed limits, 0: presets |
| cfg_oversample | input | 1 | Halve measured widths |
| cfg_progressive | input | 1 | 0: standard definition, 1: progressive |
| cfg_pal | input | 1 | 1: PAL preset, 0: NTSC preset |
| detected | output | 1 | Per-frame detect flag |

## Verification
The assertions rely on these input conditions:
- `frame_start` and `line_start` never fire in the same cycle.
- The configuration stays constant within a frame.
- No pulse ends in the cycle of the closing line strobe.

The stimulus meets them by design. Each task changes the configuration only between frames. The strobes go out on separate cycles. Every pulse goes out two cycles after its line strobe and ends at least two cycles before the next one.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  localparam int LINE_W = 6;
  localparam int LIM_W  = 4;
  localparam int REQ_W  = 3;

  typedef logic [LINE_W-1:0] line_t;
  typedef logic [LIM_W-1:0]  lim_t;

  typedef struct packed {
    line_t first;
    line_t last;
    lim_t  wmin;
    lim_t  wmax;
  } limits_t;

  // Built-in window and width presets, indexed by scan mode and colour system
  function automatic limits_t preset_limits(input logic pal, input logic prog);
    limits_t p;
    case ({prog, pal})
      2'b00:   p = '{first: 6'd13, last: 6'd21, wmin: 4'd6, wmax: 4'd9};
      2'b01:   p = '{first: 6'd7,  last: 6'd15, wmin: 4'd5, wmax: 4'd8};
      2'b10:   p = '{first: 6'd26, last: 6'd34, wmin: 4'd3, wmax: 4'd5};
      default: p = '{first: 6'd20, last: 6'd28, wmin: 4'd3, wmax: 4'd5};
    endcase
    return p;
  endfunction

  // Required pulse count from the two-bit code
  function automatic logic [REQ_W-1:0] required_pulses(input logic [1:0] sel);
    case (sel)
      2'b00:   return 3'd6;
      2'b01:   return 3'd4;
      2'b10:   return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

  // First line of the final three-line tail, clipped to the window start
  function automatic line_t tail_first(input line_t first, input line_t last);
    if ({1'b0, last} >= ({1'b0, first} + 7'd2)) return last - 6'd2;
    return first;
  endfunction
endpackage

// File: rtl/cpd_line_tracker.sv
module cpd_line_tracker
  import cpd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  line_start,
  input  logic  frame_start,
  output line_t line_now
);
  localparam line_t LINE_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                   line_now <= '0;
    else if (frame_start)         line_now <= line_t'(1);
    else if (line_start && line_now != LINE_MAX)
                                  line_now <= line_now + line_t'(1);
  end

  AST_FRAME_LINE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> line_now == line_t'(1)); // R4
  AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_start && line_now != LINE_MAX) |=> line_now == $past(line_now) + line_t'(1)); // R4
endmodule

// File: rtl/cpd_pulse_meter.sv
module cpd_pulse_meter
  import cpd_pkg::*;
#(
  parameter int MEAS_W = 6
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              oversample,
  input  line_t             line_now,
  output logic              pulse_end,
  output logic [MEAS_W-1:0] width_raw,
  output logic [MEAS_W-1:0] width_eff,
  output line_t             pulse_line
);
  logic sync_q;
  logic fall_evt;

  assign fall_evt  = sync_q & ~sync_n;
  assign pulse_end = ~sync_q & sync_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q     <= 1'b1;
      width_raw  <= '0;
      pulse_line <= '0;
    end else begin
      sync_q <= sync_n;
      if (fall_evt) begin
        width_raw  <= MEAS_W'(1);
        pulse_line <= line_now;
      end else if (!sync_n && width_raw != '1) begin
        width_raw <= width_raw + MEAS_W'(1);
      end
    end
  end

  assign width_eff = oversample ? (width_raw >> 1) : width_raw;

  AST_PULSE_HAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_end |-> width_raw != '0); // R2
  AST_OVS_NOT_WIDER: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_end && oversample) |-> (width_eff < width_raw || width_raw == MEAS_W'(1))); // R3
endmodule

// File: rtl/cpd_pulse_tally.sv
module cpd_pulse_tally
  import cpd_pkg::*;
#(
  parameter int MEAS_W = 6,
  parameter int CNT_W  = 5
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse_end,
  input  logic [MEAS_W-1:0] width_eff,
  input  line_t             pulse_line,
  input  line_t             line_now,
  input  logic              line_start,
  input  logic              frame_start,
  input  limits_t           lim,
  input  logic [REQ_W-1:0]  required,
  input  logic              progressive,
  output logic              detected
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] total_cnt, tail_cnt, total_nx, tail_nx;
  logic width_ok, in_win, in_tail, hit, tail_hit, eval_now;
  line_t tail_lo;

  assign tail_lo  = tail_first(lim.first, lim.last);
  assign width_ok = (width_eff >= MEAS_W'(lim.wmin)) && (width_eff <= MEAS_W'(lim.wmax));
  assign in_win   = (pulse_line >= lim.first) && (pulse_line <= lim.last);
  assign in_tail  = (pulse_line >= tail_lo) && (pulse_line <= lim.last);
  assign hit      = pulse_end && width_ok && in_win;
  assign tail_hit = hit && in_tail;
  assign eval_now = line_start && !frame_start && (line_now == lim.last);

  assign total_nx = (hit && total_cnt != CNT_MAX) ? total_cnt + CNT_W'(1) : total_cnt;
  assign tail_nx  = (tail_hit && tail_cnt != CNT_MAX) ? tail_cnt + CNT_W'(1) : tail_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total_cnt <= '0;
      tail_cnt  <= '0;
      detected  <= 1'b0;
    end else begin
      if (frame_start) begin
        total_cnt <= '0;
        tail_cnt  <= '0;
      end else begin
        total_cnt <= total_nx;
        tail_cnt  <= tail_nx;
      end
      if (eval_now)
        detected <= (progressive ? total_nx : tail_nx) >= CNT_W'(required);
    end
  end

  AST_TAIL_WITHIN_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    tail_cnt <= total_cnt); // R5
  AST_CLEAR_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (total_cnt == '0 && tail_cnt == '0)); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_now |=> $stable(detected)); // R9
endmodule

// File: rtl/cpd_detector.sv
module cpd_detector
  import cpd_pkg::*;
#(
  parameter int MEAS_W = 6,
  parameter int CNT_W  = 5
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_n,
  input  logic       line_start,
  input  logic       frame_start,
  input  logic [3:0] cfg_wmin,
  input  logic [3:0] cfg_wmax,
  input  logic [5:0] cfg_first,
  input  logic [5:0] cfg_last,
  input  logic [1:0] cfg_count_sel,
  input  logic       cfg_use_prog,
  input  logic       cfg_oversample,
  input  logic       cfg_progressive,
  input  logic       cfg_pal,
  output logic       detected
);
  line_t             line_now, pulse_line;
  logic              pulse_end;
  logic [MEAS_W-1:0] width_raw, width_eff;
  limits_t           lim_prog, lim_eff;
  logic [REQ_W-1:0]  required;

  assign lim_prog = '{first: cfg_first, last: cfg_last, wmin: cfg_wmin, wmax: cfg_wmax};
  assign lim_eff  = cfg_use_prog ? lim_prog : preset_limits(cfg_pal, cfg_progressive);
  assign required = required_pulses(cfg_count_sel);

  cpd_line_tracker u_lines (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .frame_start(frame_start), .line_now(line_now)
  );

  cpd_pulse_meter #(.MEAS_W(MEAS_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .oversample(cfg_oversample),
    .line_now(line_now), .pulse_end(pulse_end), .width_raw(width_raw),
    .width_eff(width_eff), .pulse_line(pulse_line)
  );

  cpd_pulse_tally #(.MEAS_W(MEAS_W), .CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .pulse_end(pulse_end), .width_eff(width_eff),
    .pulse_line(pulse_line), .line_now(line_now), .line_start(line_start),
    .frame_start(frame_start), .lim(lim_eff), .required(required),
    .progressive(cfg_progressive), .detected(detected)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> !detected); // R1
endmodule

// File: tb/tb_cpd_detector.sv
`timescale 1ns/1ps
module tb_cpd_detector;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, sync_n, line_start, frame_start;
  logic [3:0] cfg_wmin, cfg_wmax;
  logic [5:0] cfg_first, cfg_last;
  logic [1:0] cfg_count_sel;
  logic cfg_use_prog, cfg_oversample, cfg_progressive, cfg_pal;
  logic detected;

  int n_checks = 0;
  int n_fail   = 0;
  int pcount[64];
  int pwidth[64];

  cpd_detector dut (.*);

  task automatic check(input logic got, input logic exp, input string req);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: detected=%0b expected=%0b", req, got, exp);
    end
  endtask

  task automatic clear_pulses();
    for (int i = 0; i < 64; i++) begin pcount[i] = 0; pwidth[i] = 7; end
  endtask

  // Bench view of the limits (R7, R8)
  function automatic void limits(output int f, output int l, output int mn, output int mx);
    if (cfg_use_prog) begin
      f = cfg_first; l = cfg_last; mn = cfg_wmin; mx = cfg_wmax;
    end else if (!cfg_progressive) begin
      if (cfg_pal) begin f = 7;  l = 15; mn = 5; mx = 8; end
      else         begin f = 13; l = 21; mn = 6; mx = 9; end
    end else begin
      if (cfg_pal) begin f = 20; l = 28; mn = 3; mx = 5; end
      else         begin f = 26; l = 34; mn = 3; mx = 5; end
    end
  endfunction

  function automatic logic model();
    int f, l, mn, mx, lo, need, cnt, w;
    limits(f, l, mn, mx);
    lo = (l - 2 >= f) ? l - 2 : f;
    need = (cfg_count_sel == 2'b00) ? 6 : (cfg_count_sel == 2'b01) ? 4 :
           (cfg_count_sel == 2'b10) ? 5 : 7;
    cnt = 0;
    for (int ln = 1; ln < 64; ln++) begin
      w = cfg_oversample ? pwidth[ln] / 2 : pwidth[ln];
      if (w >= mn && w <= mx && ln <= l && ln >= (cfg_progressive ? f : lo))
        cnt += pcount[ln];
    end
    return cnt >= need;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Runs one frame; with close set, issues the strobe that ends the last window line
  task automatic run_frame(input bit close);
    int f, l, mn, mx;
    limits(f, l, mn, mx);
    frame_start = 1'b1; tick(1); frame_start = 1'b0;
    for (int ln = 1; ln <= l; ln++) begin
      if (ln > 1) begin line_start = 1'b1; tick(1); line_start = 1'b0; end
      tick(2);
      for (int k = 0; k < pcount[ln]; k++) begin
        sync_n = 1'b0; tick(pwidth[ln]); sync_n = 1'b1; tick(3);
      end
      tick(2);
    end
    if (close) begin line_start = 1'b1; tick(1); line_start = 1'b0; tick(2); end
  endtask

  task automatic set_cfg(input bit up, input bit pg, input bit pal, input bit ovs,
                         input logic [1:0] sel, input int f, input int l,
                         input int mn, input int mx);
    cfg_use_prog = up; cfg_progressive = pg; cfg_pal = pal; cfg_oversample = ovs;
    cfg_count_sel = sel; cfg_first = 6'(f); cfg_last = 6'(l);
    cfg_wmin = 4'(mn); cfg_wmax = 4'(mx);
  endtask

  task automatic t_reset();
    check(detected, 1'b0, "R1 reset");
    clear_pulses(); run_frame(1'b0);
    check(detected, 1'b0, "R1 before first evaluation");
    line_start = 1'b1; tick(1); line_start = 1'b0; tick(2);
  endtask

  task automatic t_counts();
    set_cfg(0, 0, 0, 0, 2'b10, 40, 50, 0, 0);
    clear_pulses(); pcount[19] = 2; pcount[21] = 3;
    run_frame(1'b1); check(detected, model(), "R5 five of five");
    pcount[21] = 2; run_frame(1'b1); check(detected, model(), "R5 four of five");
    cfg_count_sel = 2'b01; run_frame(1'b1); check(detected, model(), "R5 code 01");
    cfg_count_sel = 2'b11; pcount[20] = 2; run_frame(1'b1);
    check(detected, model(), "R5 code 11 six");
    pcount[20] = 3; run_frame(1'b1); check(detected, model(), "R5 code 11 seven");
    cfg_count_sel = 2'b00; clear_pulses(); pcount[15] = 6; pcount[21] = 5;
    run_frame(1'b1); check(detected, model(), "R5 outside tail");
  endtask

  task automatic t_widths();
    int ws[4] = '{5, 6, 9, 10};
    foreach (ws[i]) begin
      set_cfg(1, 0, 0, 0, 2'b10, 13, 21, 6, 9);
      clear_pulses(); pcount[20] = 5; pwidth[20] = ws[i];
      run_frame(1'b1); check(detected, model(), $sformatf("R2 width %0d", ws[i]));
    end
  endtask

  task automatic t_oversample();
    int ws[4] = '{12, 20, 11, 19};
    foreach (ws[i]) begin
      set_cfg(1, 0, 0, 1, 2'b10, 13, 21, 6, 9);
      clear_pulses(); pcount[19] = 5; pwidth[19] = ws[i];
      run_frame(1'b1); check(detected, model(), $sformatf("R3 raw width %0d", ws[i]));
    end
  endtask

  task automatic t_window_prog();
    set_cfg(1, 1, 0, 0, 2'b10, 5, 10, 6, 9);
    clear_pulses(); pcount[5] = 3; pcount[6] = 2;
    run_frame(1'b1); check(detected, model(), "R6 progressive early lines");
    cfg_progressive = 1'b0; run_frame(1'b1); check(detected, model(), "R5 same in standard");
    cfg_progressive = 1'b1; pcount[5] = 0; pcount[4] = 3;
    run_frame(1'b1); check(detected, model(), "R4 line before window");
    set_cfg(1, 0, 0, 0, 2'b01, 5, 6, 6, 9);
    clear_pulses(); pcount[5] = 2; pcount[6] = 2;
    run_frame(1'b1); check(detected, model(), "R5 tail clipped to first");
  endtask

  task automatic t_presets();
    set_cfg(0, 0, 1, 0, 2'b10, 1, 3, 1, 2);
    clear_pulses(); pcount[13] = 2; pcount[15] = 3; pwidth[13] = 5; pwidth[15] = 5;
    run_frame(1'b1); check(detected, model(), "R8 PAL preset");
    cfg_pal = 1'b0; run_frame(1'b1); check(detected, model(), "R8 NTSC preset");
    set_cfg(0, 1, 0, 0, 2'b01, 1, 3, 1, 2);
    clear_pulses(); pcount[27] = 4; pwidth[27] = 4;
    run_frame(1'b1); check(detected, model(), "R7 progressive NTSC preset");
    set_cfg(1, 0, 0, 0, 2'b10, 13, 21, 6, 9);
    clear_pulses(); pcount[20] = 5; pwidth[20] = 7;
    run_frame(1'b1); check(detected, model(), "R7 programmed match");
    cfg_first = 6'd1; cfg_last = 6'd3; cfg_use_prog = 1'b0;
    run_frame(1'b1); check(detected, model(), "R7 programmed ignored");
  endtask

  task automatic t_hold();
    set_cfg(0, 0, 0, 0, 2'b10, 0, 0, 0, 0);
    clear_pulses(); pcount[20] = 5;
    run_frame(1'b1); check(detected, 1'b1, "R9 set");
    clear_pulses(); run_frame(1'b0);
    check(detected, 1'b1, "R9 hold before evaluation");
    line_start = 1'b1; tick(1); line_start = 1'b0; tick(2);
    check(detected, 1'b0, "R9 cleared at evaluation");
  endtask

  initial begin
    rst_n = 1'b0; sync_n = 1'b1; line_start = 1'b0; frame_start = 1'b0;
    set_cfg(0, 0, 0, 0, 2'b10, 13, 21, 6, 9);
    tick(4); rst_n = 1'b1; tick(2);
    t_reset();
    t_counts();
    t_widths();
    t_oversample();
    t_window_prog();
    t_presets();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule